// File: doc/BRIEF.md
# Volatile Status Write Control

This block is the status-register control path of a serial NOR flash slave. It keeps two copies of the status bits. One is a non-volatile image that stands in for the stored bits. The other is a volatile working copy, and that is the value the rest of the device uses. When reset is released, the working copy is loaded from the image. From then on, a status write lands either in the working copy alone, at once and without wearing the stored bits, or in both copies together with a start pulse for the slow non-volatile write cycle.

Commands arrive on a serial interface made of an active-low chip select, a serial clock and a serial data input. The three lines are synchronized into the system clock domain and sampled there. A dedicated one-shot arming command routes the next status write to the working copy only. This command leaves the write-enable latch untouched. The arm is spent by the next completed command, whatever that command is. A status write that finds neither the arm nor the latch set is dropped.

Top module: `svw_status_ctrl`

## Requirements
- R1: While reset is asserted, wel_o is 0, nv_wr_o is 0, status_o is 0 and nv_status_o equals NV_INIT. On the first clock edge after reset is released, status_o takes the value of nv_status_o.
- R2: Serial data is shifted in MSB first on rising sclk_i while cs_ni is low. A command acts only if cs_ni rises after a whole, nonzero number of bytes. Any other frame, including one with no clock edges, changes nothing, and both the arm and the latch keep their values.
- R3: Opcode 0x06 sets the write-enable latch. Opcode 0x04 clears it. Both also drop a pending arm.
- R4: Opcode 0x50 arms a volatile write and leaves wel_o unchanged.
- R5: The status write opcode 0x01, followed by a data byte, arrives while armed. The working copy takes the data and drops the arm. nv_status_o and wel_o do not change, and nv_wr_o stays low. This also holds when the latch is set.
- R6: The arm serves only one status write. A second 0x01 without a fresh 0x50 is handled as if the arm had never been set.
- R7: 0x01 arrives with the latch set and no arm. Both copies take the data, nv_wr_o pulses for one clock, and the latch clears.
- R8: 0x01 with neither the arm nor the latch set changes nothing.
- R9: Any completed opcode other than 0x50, 0x01, 0x06 and 0x04 clears the arm and changes nothing else.
- R10: Bits that are 0 in WR_MASK never change in either copy.
- R11: A 0x01 frame carrying fewer than SR_BYTES data bytes changes neither copy nor the latch, but it clears the arm. Data bytes beyond SR_BYTES are ignored. Data byte k (counted from 1) fills status bits [8k-1:8k-8].
- R12: Outputs change on the SYNC_STAGES+1-th rising clk_i edge after cs_ni rises, and nv_wr_o is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| status_o | output | 8*SR_BYTES | Volatile working status copy |
| nv_status_o | output | 8*SR_BYTES | Non-volatile status image |
| wel_o | output | 1 | Write-enable latch |
| nv_wr_o | output | 1 | One-cycle start of a non-volatile write |

## Verification
Some properties are checked by the assertions on every cycle:
- the non-volatile image changes only together with the start pulse, and that pulse lasts a single cycle and leaves the latch clear;
- a latch rise, a working-copy change and a pulse each trace back to the decoded command of the cycle before;
- the arm never outlives a completed non-arming command;
- masked bits never move.

The bench scenarios are needed for the rest: the frame-alignment rule, the order-dependent arming sequences (arm then write, arm then other opcode, arm with the latch also set), short and over-long write frames, and the exact cycle at which each effect appears relative to the rise of chip select.

// File: rtl/svw_pkg.sv
package svw_pkg;
  localparam logic [7:0] OP_VOL_ARM   = 8'h50;
  localparam logic [7:0] OP_WR_STATUS = 8'h01;
  localparam logic [7:0] OP_WEL_SET   = 8'h06;
  localparam logic [7:0] OP_WEL_CLR   = 8'h04;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ARM,
    CMD_WEL_SET,
    CMD_WEL_CLR,
    CMD_WRSR,
    CMD_WRSR_SHORT,
    CMD_OTHER
  } cmd_kind_e;
endpackage

// File: rtl/svw_sync.sv
module svw_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/svw_spi_rx.sv
module svw_spi_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_MAX     = 2,
  localparam int CNT_W      = $clog2(CNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             sdi_i,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic [CNT_W-1:0] byte_idx_o,
  output logic             frame_end_o,
  output logic             frame_ok_o,
  output logic [CNT_W-1:0] frame_bytes_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(CNT_MAX);

  logic cs_s, sclk_s, sdi_s;
  logic cs_q, sclk_q;
  logic sclk_rise;
  logic [2:0]       bit_cnt_q;
  logic [6:0]       shift_q;
  logic [CNT_W-1:0] byte_cnt_q;

  svw_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, sdi_i}),
    .q_o    ({cs_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q & ~cs_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      shift_q    <= '0;
    end else if (cs_s) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
    end else if (sclk_rise) begin
      shift_q   <= {shift_q[5:0], sdi_s};
      bit_cnt_q <= bit_cnt_q + 3'd1;
      if (bit_cnt_q == 3'd7 && byte_cnt_q != CNT_SAT)
        byte_cnt_q <= byte_cnt_q + CNT_W'(1);
    end
  end

  assign byte_vld_o    = sclk_rise && (bit_cnt_q == 3'd7);
  assign byte_o        = {shift_q, sdi_s};
  assign byte_idx_o    = byte_cnt_q;
  // counters still hold the frame totals in the cycle the rise is seen
  assign frame_end_o   = cs_s & ~cs_q;
  assign frame_ok_o    = (bit_cnt_q == 3'd0) && (byte_cnt_q != '0);
  assign frame_bytes_o = byte_cnt_q;
endmodule

// File: rtl/svw_cmd_decode.sv
module svw_cmd_decode
  import svw_pkg::*;
#(
  parameter int  SR_BYTES = 1,
  parameter int  CNT_W    = 2,
  localparam int SR_W     = 8 * SR_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic [CNT_W-1:0] byte_idx_i,
  input  logic             frame_end_i,
  input  logic             frame_ok_i,
  input  logic [CNT_W-1:0] frame_bytes_i,
  output logic             cmd_vld_o,
  output cmd_kind_e        cmd_kind_o,
  output logic [SR_W-1:0]  cmd_data_o
);
  localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(SR_BYTES + 1);

  logic [7:0] opcode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            opcode_q <= '0;
    else if (byte_vld_i && byte_idx_i == '0) opcode_q <= byte_i;
  end

  for (genvar k = 1; k <= SR_BYTES; k++) begin : g_data
    logic [7:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     b_q <= '0;
      else if (byte_vld_i && byte_idx_i == CNT_W'(k)) b_q <= byte_i;
    end
    assign cmd_data_o[8*k-1 -: 8] = b_q;
  end

  assign cmd_vld_o = frame_end_i && frame_ok_i;

  always_comb begin
    cmd_kind_o = CMD_NONE;
    if (cmd_vld_o) begin
      case (opcode_q)
        OP_VOL_ARM:   cmd_kind_o = CMD_ARM;
        OP_WEL_SET:   cmd_kind_o = CMD_WEL_SET;
        OP_WEL_CLR:   cmd_kind_o = CMD_WEL_CLR;
        OP_WR_STATUS: cmd_kind_o = (frame_bytes_i >= FULL_LEN) ? CMD_WRSR : CMD_WRSR_SHORT;
        default:      cmd_kind_o = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/svw_status_regs.sv
module svw_status_regs
  import svw_pkg::*;
#(
  parameter int              SR_W    = 8,
  parameter logic [SR_W-1:0] NV_INIT = '0,
  parameter logic [SR_W-1:0] WR_MASK = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_vld_i,
  input  cmd_kind_e       cmd_kind_i,
  input  logic [SR_W-1:0] cmd_data_i,
  output logic [SR_W-1:0] vol_o,
  output logic [SR_W-1:0] nv_o,
  output logic            wel_o,
  output logic            arm_o,
  output logic            nv_wr_o
);
  logic [SR_W-1:0] vol_q, nv_q;
  logic            wel_q, arm_q, nv_wr_q, copy_pend_q;
  logic [SR_W-1:0] vol_merged, nv_merged;

  assign vol_merged = (vol_q & ~WR_MASK) | (cmd_data_i & WR_MASK);
  assign nv_merged  = (nv_q  & ~WR_MASK) | (cmd_data_i & WR_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q       <= '0;
      nv_q        <= NV_INIT;
      wel_q       <= 1'b0;
      arm_q       <= 1'b0;
      nv_wr_q     <= 1'b0;
      copy_pend_q <= 1'b1;
    end else begin
      nv_wr_q <= 1'b0;
      if (copy_pend_q) begin
        // power-up load of the working copy
        vol_q       <= nv_q;
        copy_pend_q <= 1'b0;
      end else if (cmd_vld_i) begin
        case (cmd_kind_i)
          CMD_ARM:     arm_q <= 1'b1;
          CMD_WEL_SET: begin wel_q <= 1'b1; arm_q <= 1'b0; end
          CMD_WEL_CLR: begin wel_q <= 1'b0; arm_q <= 1'b0; end
          CMD_WRSR: begin
            arm_q <= 1'b0;
            if (arm_q) begin
              vol_q <= vol_merged;
            end else if (wel_q) begin
              vol_q   <= vol_merged;
              nv_q    <= nv_merged;
              nv_wr_q <= 1'b1;
              wel_q   <= 1'b0;
            end
          end
          default:     arm_q <= 1'b0;
        endcase
      end
    end
  end

  assign vol_o   = vol_q;
  assign nv_o    = nv_q;
  assign wel_o   = wel_q;
  assign arm_o   = arm_q;
  assign nv_wr_o = nv_wr_q;
endmodule

// File: rtl/svw_status_ctrl.sv
module svw_status_ctrl
  import svw_pkg::*;
#(
  parameter int                    SR_BYTES    = 1,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [8*SR_BYTES-1:0] NV_INIT     = 'h3C,
  parameter logic [8*SR_BYTES-1:0] WR_MASK     = 'hFC
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  sclk_i,
  input  logic                  sdi_i,
  output logic [8*SR_BYTES-1:0] status_o,
  output logic [8*SR_BYTES-1:0] nv_status_o,
  output logic                  wel_o,
  output logic                  nv_wr_o
);
  localparam int SR_W    = 8 * SR_BYTES;
  localparam int CNT_MAX = SR_BYTES + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             byte_vld;
  logic [7:0]       byte_d;
  logic [CNT_W-1:0] byte_idx;
  logic             frame_end, frame_ok;
  logic [CNT_W-1:0] frame_bytes;
  logic             cmd_vld;
  cmd_kind_e        cmd_kind;
  logic [SR_W-1:0]  cmd_data;
  logic             arm;

  svw_spi_rx #(
    .SYNC_STAGES (SYNC_STAGES),
    .CNT_MAX     (CNT_MAX)
  ) i_rx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cs_ni         (cs_ni),
    .sclk_i        (sclk_i),
    .sdi_i         (sdi_i),
    .byte_vld_o    (byte_vld),
    .byte_o        (byte_d),
    .byte_idx_o    (byte_idx),
    .frame_end_o   (frame_end),
    .frame_ok_o    (frame_ok),
    .frame_bytes_o (frame_bytes)
  );

  svw_cmd_decode #(
    .SR_BYTES (SR_BYTES),
    .CNT_W    (CNT_W)
  ) i_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .byte_vld_i    (byte_vld),
    .byte_i        (byte_d),
    .byte_idx_i    (byte_idx),
    .frame_end_i   (frame_end),
    .frame_ok_i    (frame_ok),
    .frame_bytes_i (frame_bytes),
    .cmd_vld_o     (cmd_vld),
    .cmd_kind_o    (cmd_kind),
    .cmd_data_o    (cmd_data)
  );

  svw_status_regs #(
    .SR_W    (SR_W),
    .NV_INIT (NV_INIT),
    .WR_MASK (WR_MASK)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_vld_i  (cmd_vld),
    .cmd_kind_i (cmd_kind),
    .cmd_data_i (cmd_data),
    .vol_o      (status_o),
    .nv_o       (nv_status_o),
    .wel_o      (wel_o),
    .arm_o      (arm),
    .nv_wr_o    (nv_wr_o)
  );
endmodule

// File: rtl/svw_status_chk.sv
module svw_status_chk
  import svw_pkg::*;
#(
  parameter int              SR_W    = 8,
  parameter logic [SR_W-1:0] WR_MASK = '1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [SR_W-1:0] status_o,
  input logic [SR_W-1:0] nv_status_o,
  input logic            wel_o,
  input logic            nv_wr_o,
  input logic            cmd_vld_i,
  input cmd_kind_e       cmd_kind_i,
  input logic            arm_i
);
  logic [1:0] up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          up_q <= '0;
    else if (up_q != 2'd2) up_q <= up_q + 2'd1;
  end

  p_strobe_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_wr_o |=> !nv_wr_o);

  p_nv_needs_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nv_status_o != $past(nv_status_o)) |-> nv_wr_o);

  p_strobe_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_wr_o |-> $past(cmd_vld_i && cmd_kind_i == CMD_WRSR && wel_o && !arm_i));

  p_strobe_clears_wel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_wr_o |-> !wel_o);

  p_wel_set_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_o) |-> $past(cmd_vld_i && cmd_kind_i == CMD_WEL_SET));

  p_arm_keeps_wel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_vld_i && cmd_kind_i == CMD_ARM) |-> $stable(wel_o));

  p_arm_spent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_vld_i && cmd_kind_i != CMD_ARM) |-> !arm_i);

  p_vol_change_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q == 2'd2 && status_o != $past(status_o)) |-> $past(cmd_vld_i && cmd_kind_i == CMD_WRSR));

  p_vol_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q == 2'd2) |-> (((status_o ^ $past(status_o)) & ~WR_MASK) == '0));

  p_nv_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((nv_status_o ^ $past(nv_status_o)) & ~WR_MASK) == '0));
endmodule

bind svw_status_ctrl svw_status_chk #(
  .SR_W    (SR_W),
  .WR_MASK (WR_MASK)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .status_o    (status_o),
  .nv_status_o (nv_status_o),
  .wel_o       (wel_o),
  .nv_wr_o     (nv_wr_o),
  .cmd_vld_i   (cmd_vld),
  .cmd_kind_i  (cmd_kind),
  .arm_i       (arm)
);

// File: tb/test_svw_status_ctrl.sv
module test_svw_status_ctrl;
  localparam int         SR_BYTES = 1;
  localparam int         SYNC     = 2;
  localparam int         LAT      = SYNC + 1;
  localparam int         HALF     = 3;
  localparam logic [7:0] NV_INIT  = 8'h3C;
  localparam logic [7:0] MASK     = 8'hFC;

  logic clk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [7:0] status_o, nv_status_o;
  logic       wel_o, nv_wr_o;

  always #2 clk = ~clk;

  svw_status_ctrl #(
    .SR_BYTES (SR_BYTES), .SYNC_STAGES (SYNC), .NV_INIT (NV_INIT), .WR_MASK (MASK)
  ) i_svw_status_ctrl (
    .clk_i (clk), .rst_ni (rst_ni), .cs_ni (cs_ni), .sclk_i (sclk), .sdi_i (sdi),
    .status_o (status_o), .nv_status_o (nv_status_o), .wel_o (wel_o), .nv_wr_o (nv_wr_o)
  );

  int    n_cmp = 0, n_bad = 0, cyc = 0, strobe_seen = 0;
  string cur_req = "R1";
  bit    cmp_en = 0;

  logic [7:0] m_vol = '0, m_nv = NV_INIT;
  bit         m_wel = 0, m_arm = 0, m_strobe = 0;
  bit         p_on = 0, p_wel = 0, p_arm = 0, p_strobe = 0;
  int         p_due = 0;
  logic [7:0] p_vol = '0, p_nv = '0;

  function automatic logic [7:0] mrg(logic [7:0] o, logic [7:0] d);
    return (o & ~MASK) | (d & MASK);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    m_strobe = 0;
    if (p_on && cyc == p_due) begin
      m_vol = p_vol; m_nv = p_nv; m_wel = p_wel; m_arm = p_arm; m_strobe = p_strobe;
      p_on = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      check(cur_req, "status_o", status_o, m_vol);
      check(cur_req, "nv_status_o", nv_status_o, m_nv);
      check(cur_req, "wel_o", wel_o, m_wel);
      check(cur_req, "nv_wr_o R12", nv_wr_o, m_strobe);
      if (nv_wr_o) strobe_seen++;
    end
  end

  // behavioural model of one completed frame
  task automatic model_frame(int n, logic [7:0] b0, logic [7:0] b1, int extra);
    p_vol = m_vol; p_nv = m_nv; p_wel = m_wel; p_arm = m_arm; p_strobe = 0;
    if (extra == 0 && n > 0) begin
      case (b0)
        8'h50: p_arm = 1;
        8'h06: begin p_wel = 1; p_arm = 0; end
        8'h04: begin p_wel = 0; p_arm = 0; end
        8'h01: begin
          p_arm = 0;
          if (n >= 1 + SR_BYTES) begin
            if (m_arm) p_vol = mrg(m_vol, b1);
            else if (m_wel) begin
              p_vol = mrg(m_vol, b1); p_nv = mrg(m_nv, b1); p_strobe = 1; p_wel = 0;
            end
          end
        end
        default: p_arm = 0;
      endcase
    end
    p_due = cyc + LAT;
    p_on  = 1;
  endtask

  task automatic send_bit(logic b);
    sdi = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send(int n, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, int extra);
    logic [7:0] bytes [3];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    @(negedge clk);
    cs_ni = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++)
      for (int j = 7; j >= 0; j--) send_bit(bytes[i][j]);
    for (int e = 0; e < extra; e++) send_bit(1'b1);
    repeat (HALF) @(negedge clk);
    cs_ni = 1'b1;
    model_frame(n, b0, b1, extra);
    repeat (8) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog: actual=timeout expected=finished");
    report();
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    check("R1", "status_o in reset", status_o, 8'h00);
    check("R1", "nv_status_o in reset", nv_status_o, NV_INIT);
    check("R1", "wel_o in reset", wel_o, 0);
    check("R1", "nv_wr_o in reset", nv_wr_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "power-up copy", status_o, NV_INIT);
    m_vol = NV_INIT; m_nv = NV_INIT;
    cmp_en = 1;

    cur_req = "R8";  send(2, 8'h01, 8'hA5, 8'h00, 0);
    cur_req = "R4";  send(1, 8'h50, 8'h00, 8'h00, 0);
    cur_req = "R5";  send(2, 8'h01, 8'hA5, 8'h00, 0);
    cur_req = "R6";  send(2, 8'h01, 8'h5A, 8'h00, 0);
    cur_req = "R3";  send(1, 8'h06, 8'h00, 8'h00, 0);
    cur_req = "R7";  s0 = strobe_seen;
    send(2, 8'h01, 8'h81, 8'h00, 0);
    check("R12", "strobe cycles per write", strobe_seen - s0, 1);
    cur_req = "R3";  send(1, 8'h06, 8'h00, 8'h00, 0);
    send(1, 8'h04, 8'h00, 8'h00, 0);
    cur_req = "R9";  send(1, 8'h50, 8'h00, 8'h00, 0);
    send(1, 8'h9F, 8'h00, 8'h00, 0);
    send(2, 8'h01, 8'h77, 8'h00, 0);
    send(1, 8'h06, 8'h00, 8'h00, 0);
    send(1, 8'h50, 8'h00, 8'h00, 0);
    send(1, 8'h05, 8'h00, 8'h00, 0);
    send(2, 8'h01, 8'h6B, 8'h00, 0);
    cur_req = "R2";  send(1, 8'h06, 8'h00, 8'h00, 0);
    send(1, 8'h50, 8'h00, 8'h00, 3);
    send(2, 8'h01, 8'hE7, 8'h00, 5);
    send(0, 8'h00, 8'h00, 8'h00, 0);
    send(2, 8'h50, 8'h01, 8'h00, 0);
    cur_req = "R10"; send(1, 8'h50, 8'h00, 8'h00, 0);
    send(2, 8'h01, 8'hFF, 8'h00, 0);
    cur_req = "R6";  send(2, 8'h01, 8'h03, 8'h00, 0);
    cur_req = "R11"; send(1, 8'h06, 8'h00, 8'h00, 0);
    send(1, 8'h50, 8'h00, 8'h00, 0);
    send(1, 8'h01, 8'h00, 8'h00, 0);
    send(3, 8'h01, 8'hC3, 8'h77, 0);
    cur_req = "R4";  send(1, 8'h06, 8'h00, 8'h00, 0);
    send(1, 8'h50, 8'h00, 8'h00, 0);
    check("R4", "wel_o after arm", wel_o, 1);
    cur_req = "R5";  send(2, 8'h01, 8'h28, 8'h00, 0);
    check("R5", "wel_o kept by volatile write", wel_o, 1);
    report();
  end
endmodule